// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Controller

This controller connects a simple single-bit host port to a 65,536 x 1 dynamic memory array organised as 256 rows by 256 columns. The memory has only eight address pins. The controller sends each 16-bit host address in two halves over those pins. The row half goes first and is captured by a falling row strobe. The column half follows and is captured by a falling column strobe. Both strobes are active-low and are held for programmable numbers of clock cycles.

Dynamic cells lose their charge, so the controller also runs its own refresh. A timer raises a refresh request every `REF_INT` clocks. A refresh cycle pulses only the row strobe, with an internal row counter on the address pins. The counter then moves on to the next row, wrapping after row 255, so every row is visited within a bounded interval. A pending refresh wins over a waiting host request. It never cuts into an access that has already started.

The host raises `req` with its address, direction and write bit, and holds them until `done`. `busy` stays high while any memory cycle or precharge is in progress. For a read, `rdata` is valid in the cycle where `done` pulses, which is the cycle after the column strobe has been held for its full time.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset, `mem_ras_n` and `mem_cas_n` are 1, and `busy` and `done` are 0.
- R2: For a host access, the upper 8 address bits (15:8) are on `mem_a` when `mem_ras_n` falls. `mem_ras_n` is then low for exactly `RAS_CYC` cycles before `mem_cas_n` falls.
- R3: The lower 8 address bits (7:0) are on `mem_a` while `mem_cas_n` is low. `mem_cas_n` stays low for exactly `CAS_CYC` cycles. `mem_cas_n` is never low while `mem_ras_n` is high.
- R4: While `mem_cas_n` is low, `mem_we_n` is 0 and `mem_d` equals the host write bit for a write (`we`=1). For a read (`we`=0), `mem_we_n` is 1.
- R5: `done` is a one-cycle pulse in the cycle where `mem_cas_n` has just returned high. For a read, `rdata` then equals the bit last written to that address.
- R6: Between two row-strobe low periods, `mem_ras_n` stays high for at least `PRE_CYC` cycles. Whenever `busy` is 0, both strobes are high.
- R7: A refresh cycle holds `mem_ras_n` low for `RAS_CYC` cycles and keeps `mem_cas_n` high. `mem_a` carries the refresh row, which is 0 for the first refresh after reset and rises by one, modulo 256, with each refresh.
- R8: A refresh starts every `REF_INT` clocks. The gap between the ends of two consecutive refreshes never exceeds `REF_INT + 2*RAS_CYC + CAS_CYC + PRE_CYC + 4` cycles.
- R9: Under continuous back-to-back host requests, refreshes still occur within the R8 bound, and each access that has begun completes with its full strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until `done` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Host address, row in bits 15:8 and column in bits 7:0 |
| wdata | input | 1 | Write bit |
| busy | output | 1 | A memory cycle or precharge is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 1 | Read bit, valid when `done` is high |
| mem_a | output | 8 | Multiplexed row/column address to the memory |
| mem_ras_n | output | 1 | Row strobe, active-low |
| mem_cas_n | output | 1 | Column strobe, active-low |
| mem_we_n | output | 1 | Memory write enable, active-low |
| mem_d | output | 1 | Write bit to the memory |
| mem_q | input | 1 | Read bit from the memory |

## Verification
The assertions check strobe timing on every cycle. The column strobe must stay inside the row strobe and must last exactly its programmed width. The row strobe must meet its minimum width, and precharge must meet its minimum length. Both strobes must be idle whenever `busy` is low. `done` must be a single pulse aligned to the rise of the column strobe, and the interval between refreshes must stay within its bound. Only the bench's scenarios can show that the right row and column halves reach the pins and that read data matches earlier writes. The same goes for the refresh row sequence wrapping past 255, and for refresh still winning over back-to-back host traffic.

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int AW      = 8,
  parameter int RAS_CYC = 3,
  parameter int CAS_CYC = 2,
  parameter int PRE_CYC = 2,
  parameter int REF_INT = 780
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [2*AW-1:0] addr,
  input  logic          wdata,
  output logic          busy,
  output logic          done,
  output logic          rdata,
  output logic [AW-1:0] mem_a,
  output logic          mem_ras_n,
  output logic          mem_cas_n,
  output logic          mem_we_n,
  output logic          mem_d,
  input  logic          mem_q
);
  localparam int MAXC = (RAS_CYC > CAS_CYC) ? ((RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC)
                                            : ((CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int TW = $clog2(REF_INT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_REF, S_PRE} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic          ref_pend;
  logic [AW-1:0] ref_row;
  logic [AW-1:0] col_q;
  logic          we_q, wd_q;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      tmr       <= '0;
      ref_pend  <= 1'b0;
      ref_row   <= '0;
      col_q     <= '0;
      we_q      <= 1'b0;
      wd_q      <= 1'b0;
      done      <= 1'b0;
      rdata     <= 1'b0;
      mem_a     <= '0;
      mem_ras_n <= 1'b1;
      mem_cas_n <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_d     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (ref_pend) begin
            state     <= S_REF;
            ref_pend  <= 1'b0;
            mem_ras_n <= 1'b0;
            mem_a     <= ref_row;
          end else if (req) begin
            state     <= S_ROW;
            mem_ras_n <= 1'b0;
            mem_a     <= addr[2*AW-1:AW];
            col_q     <= addr[AW-1:0];
            we_q      <= we;
            wd_q      <= wdata;
          end
        end
        S_ROW: begin
          if (cnt == CW'(RAS_CYC - 1)) begin
            state     <= S_COL;
            cnt       <= '0;
            mem_cas_n <= 1'b0;
            mem_a     <= col_q;
            mem_we_n  <= ~we_q;
            mem_d     <= wd_q;
          end else cnt <= cnt + 1'b1;
        end
        S_COL: begin
          if (cnt == CW'(CAS_CYC - 1)) begin
            state     <= S_PRE;
            cnt       <= '0;
            rdata     <= mem_q;
            done      <= 1'b1;
            mem_ras_n <= 1'b1;
            mem_cas_n <= 1'b1;
            mem_we_n  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_REF: begin
          if (cnt == CW'(RAS_CYC - 1)) begin
            state     <= S_PRE;
            cnt       <= '0;
            mem_ras_n <= 1'b1;
            ref_row   <= ref_row + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_PRE: begin
          if (cnt == CW'(PRE_CYC - 1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
      if (tmr == TW'(REF_INT - 1)) begin
        tmr      <= '0;
        ref_pend <= 1'b1;
      end else tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int RAS_CYC = 3,
  parameter int CAS_CYC = 2,
  parameter int PRE_CYC = 2,
  parameter int REF_INT = 780
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mem_ras_n,
  input logic mem_cas_n
);
  localparam int GAP_MAX = REF_INT + 2*RAS_CYC + CAS_CYC + PRE_CYC + 4;

  int  ras_lo, cas_lo, ras_hi, since_ref;
  logic cas_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo <= 0; cas_lo <= 0; ras_hi <= 0; since_ref <= 0; cas_seen <= 1'b0;
    end else begin
      ras_lo <= mem_ras_n ? 0 : ras_lo + 1;
      ras_hi <= mem_ras_n ? ras_hi + 1 : 0;
      cas_lo <= mem_cas_n ? 0 : cas_lo + 1;
      if (!mem_cas_n) cas_seen <= 1'b1;
      else if (mem_ras_n) cas_seen <= 1'b0;
      if (mem_ras_n && ras_lo != 0 && !cas_seen) since_ref <= 0;
      else since_ref <= since_ref + 1;
    end
  end

  p_cas_inside_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> !mem_ras_n);
  p_cas_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cas_n) |-> cas_lo == CAS_CYC);
  p_ras_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) |-> ras_lo >= RAS_CYC);
  p_done_at_cas_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(mem_cas_n));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> ras_hi >= PRE_CYC);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ras_n && mem_cas_n));
  p_refresh_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    since_ref <= GAP_MAX);
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(
  .RAS_CYC(RAS_CYC), .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC), .REF_INT(REF_INT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n)
);

// File: tb/dram_mux_ctrl_bench.sv
module dram_mux_ctrl_bench;
  localparam int RAS_CYC = 2;
  localparam int CAS_CYC = 2;
  localparam int PRE_CYC = 1;
  localparam int REF_INT = 64;
  localparam int GAP_MAX = REF_INT + 2*RAS_CYC + CAS_CYC + PRE_CYC + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, wdata = 1'b0;
  logic [15:0] addr = '0;
  logic busy, done, rdata, mem_ras_n, mem_cas_n, mem_we_n, mem_d, mem_q;
  logic [7:0] mem_a;

  always #2 clk = ~clk;

  dram_mux_ctrl #(.AW(8), .RAS_CYC(RAS_CYC), .CAS_CYC(CAS_CYC),
                  .PRE_CYC(PRE_CYC), .REF_INT(REF_INT)) u_dram_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .mem_a(mem_a),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_d(mem_d), .mem_q(mem_q));

  logic [255:0] mem [256];
  logic [255:0] sh  [256];
  logic [7:0]   m_row = '0;
  logic         pr_ras = 1'b1, pr_cas = 1'b1;
  initial for (int i = 0; i < 256; i++) begin mem[i] = '0; sh[i] = '0; end
  assign mem_q = mem[m_row][mem_a];
  always @(posedge clk) begin
    if (!mem_ras_n && pr_ras) m_row <= mem_a;
    if (!mem_cas_n && pr_cas && !mem_we_n) mem[m_row][mem_a] <= mem_d;
    pr_ras <= mem_ras_n;
    pr_cas <= mem_cas_n;
  end

  typedef struct { logic [15:0] a; logic w; logic d; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0, refs = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic w, input logic d);
    item_t it;
    it.a = a; it.w = w;
    it.d = w ? d : sh[a[15:8]][a[7:0]];
    if (w) sh[a[15:8]][a[7:0]] = d;
    sbq.push_back(it);
    @(negedge clk);
    req = 1'b1; addr = a; we = w; wdata = d;
    do @(negedge clk); while (!done);
    req = 1'b0;
  endtask

  logic p_ras = 1'b1, p_cas = 1'b1, cas_seen = 1'b0;
  logic [7:0] ep_row = '0;
  int lo_cnt = 0, hi_cnt = 100, cas_cnt = 0, gap = 0, ref_exp = 0;

  always @(negedge clk) if (rst_n) begin
    if (!mem_cas_n && mem_ras_n) chk(0, "R3 cas outside ras", 0, 1);
    if (!busy) chk(mem_ras_n && mem_cas_n, "R6 idle strobes", {mem_ras_n, mem_cas_n}, 3);
    if (p_ras && !mem_ras_n) begin
      chk(hi_cnt >= PRE_CYC, "R6 precharge", hi_cnt, PRE_CYC);
      ep_row = mem_a; cas_seen = 1'b0; lo_cnt = 0;
    end
    if (p_cas && !mem_cas_n) begin
      cas_seen = 1'b1; cas_cnt = 0;
      chk(lo_cnt == RAS_CYC, "R2 ras before cas", lo_cnt, RAS_CYC);
      if (sbq.size() == 0) chk(0, "R3 unexpected access", 0, 1);
      else begin
        chk(ep_row == sbq[0].a[15:8], "R2 row half", ep_row, sbq[0].a[15:8]);
        chk(mem_a == sbq[0].a[7:0], "R3 column half", mem_a, sbq[0].a[7:0]);
        chk(mem_we_n == !sbq[0].w, "R4 write enable", mem_we_n, !sbq[0].w);
        if (sbq[0].w) chk(mem_d == sbq[0].d, "R4 write bit", mem_d, sbq[0].d);
      end
    end
    if (!p_cas && mem_cas_n) begin
      chk(cas_cnt == CAS_CYC, "R3 cas width", cas_cnt, CAS_CYC);
      chk(done, "R5 done at cas end", done, 1);
      if (sbq.size() != 0) begin
        if (!sbq[0].w) chk(rdata == sbq[0].d, "R5 read data", rdata, sbq[0].d);
        void'(sbq.pop_front());
      end
    end else if (done) chk(0, "R5 stray done", 1, 0);
    if (!p_ras && mem_ras_n && !cas_seen) begin
      chk(ep_row == 8'(ref_exp), "R7 refresh row", ep_row, ref_exp % 256);
      chk(lo_cnt == RAS_CYC, "R7 refresh width", lo_cnt, RAS_CYC);
      chk(gap <= GAP_MAX, "R8 refresh interval", gap, GAP_MAX);
      ref_exp++; refs++; gap = 0;
    end
    if (mem_ras_n && !p_ras) hi_cnt = 0;
    if (!mem_ras_n) lo_cnt++; else hi_cnt++;
    if (!mem_cas_n) cas_cnt++;
    gap++;
    p_ras = mem_ras_n; p_cas = mem_cas_n;
  end

  logic [15:0] s = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] v);
    logic [15:0] t = v;
    t ^= t << 7; t ^= t >> 9; t ^= t << 8;
    return t;
  endfunction

  task automatic run();
    logic [15:0] pa [6];
    logic        pd [6];
    pa = '{16'h0000, 16'hFFFF, 16'h00FF, 16'hFF00, 16'h1234, 16'h4321};
    pd = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    repeat (3) @(negedge clk);
    chk(mem_ras_n && mem_cas_n && !busy && !done, "R1 reset state",
        {mem_ras_n, mem_cas_n, busy, done}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ras_n && mem_cas_n && !busy, "R1 after release", {mem_ras_n, mem_cas_n, busy}, 3'b110);
    for (int i = 0; i < 6; i++) access(pa[i], 1'b1, pd[i]);
    for (int i = 0; i < 6; i++) access(pa[i], 1'b0, 1'b0);
    access(16'h0001, 1'b0, 1'b0);
    for (int i = 0; i < 600; i++) begin
      s = nxt(s);
      access({s[15:9], 1'b0, s[7:0]}, 1'b1, s[3]);
      access({s[15:9], 1'b0, s[7:0]}, 1'b0, 1'b0);
    end
    while (refs < 260) begin
      s = nxt(s);
      access(s, s[0], s[5]);
    end
    chk(refs >= 260, "R9 refresh under traffic", refs, 260);
    repeat (400) @(negedge clk);
    chk(refs >= 264, "R8 refresh while idle", refs, 264);
    chk(sbq.size() == 0, "R5 all accesses done", sbq.size(), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule